// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the column address of each beat of a memory burst, one address per clock. A request gives a starting column address, a burst-length code and an order select. The block then issues the beats in order. The low address bits that the burst length covers are reordered inside an aligned block. Every bit above them is copied from the start address and held for the whole burst.

Two beat orders are supported. Sequential order counts upward from the start offset and wraps to zero at the block boundary. Interleaved order takes the start offset XOR the beat index. A controller pulses `start_i` and reads `col_o` while `valid_o` is high. `last_o` marks the final beat. A new request may be placed on that final beat, so bursts can run back to back with no gap.

Top module: `burst_col_seq`

## Requirements
- R1: When idle, a start with a nonzero length code is accepted at the clock edge. From the next cycle `valid_o` is high and the first beat's `col_o` equals the start address.
- R2: The length code sets the number of beats: `blen_i` 2'b01 gives 2 beats, 2'b10 gives 4 beats and 2'b11 gives 8 beats. These cover the low 1, 2 and 3 address bits respectively.
- R3: With `order_i`=0 (sequential), the low bits of beat k are (start offset + k) modulo the burst length. For example, 8 beats starting at offset 5 give 5,6,7,0,1,2,3,4.
- R4: With `order_i`=1 (interleaved), the low bits of beat k are the start offset XOR k. For example, 8 beats starting at offset 5 give 5,4,7,6,1,0,3,2.
- R5: Every `col_o` bit above the low bits covered by the burst length equals the start address for the whole burst.
- R6: `last_o` is high together with the final beat's address and at no other time. `valid_o` is low in the following cycle unless a new burst was accepted on that final beat.
- R7: `busy_o` is high during every beat except the final one. A start presented while `busy_o` is high is ignored.
- R8: A start presented during the final beat is accepted. Its first beat follows in the very next cycle.
- R9: A start with `blen_i`=2'b00 is ignored, and the block stays idle.
- R10: A synchronous active-high `rst` clears the burst in progress. `valid_o`, `last_o` and `busy_o` are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst request strobe |
| start_addr_i | input | ADDR_W | Starting column address |
| blen_i | input | 2 | Burst length code (01=2, 10=4, 11=8, 00 ignored) |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| col_o | output | ADDR_W | Column address of the current beat |
| valid_o | output | 1 | Beat address valid |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | Burst in progress with beats still to follow |

## Verification
Two functions can fall in the same cycle: the end of one burst and the acceptance of the next. This happens when a start arrives exactly on the cycle with `last_o` high. The bench provokes it deliberately by waiting for `last_o` before raising `start_i`. It also provokes it at random with streams of requests that include starts while busy. A queue-based reference model decides acceptance from how many beats remain. It is compared every cycle against `valid_o`, `col_o`, `last_o` and `busy_o`, so any cycle that drops or duplicates a beat at the seam is reported.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        blen_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              busy_o
);
  localparam int LW = 3;

  logic              valid_q;
  logic              ilv_q;
  logic [LW-1:0]     cnt_q;
  logic [LW-1:0]     mask_q;
  logic [LW-1:0]     mask_d;
  logic [ADDR_W-1:0] base_q;
  logic [LW-1:0]     off;
  logic [LW-1:0]     low;
  logic              accept;

  always_comb begin
    case (blen_i)
      2'b01:   mask_d = 3'b001;
      2'b10:   mask_d = 3'b011;
      2'b11:   mask_d = 3'b111;
      default: mask_d = 3'b000;
    endcase
  end

  assign accept  = start_i && (blen_i != 2'b00) && (!valid_q || last_o);
  assign off     = ilv_q ? (base_q[LW-1:0] ^ cnt_q) : (base_q[LW-1:0] + cnt_q);
  assign low     = (base_q[LW-1:0] & ~mask_q) | (off & mask_q);
  assign col_o   = {base_q[ADDR_W-1:LW], low};
  assign valid_o = valid_q;
  assign last_o  = valid_q && (cnt_q == mask_q);
  assign busy_o  = valid_q && !last_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      base_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      cnt_q   <= '0;
      mask_q  <= mask_d;
      ilv_q   <= order_i;
      base_q  <= start_addr_i;
    end else if (valid_q) begin
      if (last_o) valid_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [1:0]        blen_i,
  input logic [ADDR_W-1:0] col_o,
  input logic              valid_o,
  input logic              last_o,
  input logic              busy_o
);
  a_r6_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  a_r7_busy_not_last: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (valid_o && !last_o));

  a_r7_start_ignored_busy: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (valid_o && $stable(col_o[ADDR_W-1:3])));

  a_r6_drop_after_last: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o);

  a_r8_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (last_o && start_i && blen_i != 2'b00) |=> valid_o);

  a_r9_zero_code_idle: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && start_i && blen_i == 2'b00) |=> !valid_o);
endmodule

bind burst_col_seq burst_col_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .blen_i(blen_i),
  .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .busy_o(busy_o)
);

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
  localparam int ADDR_W = 12;
  localparam time PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [1:0]        blen_i = 2'b00;
  logic              order_i = 1'b0;
  logic [ADDR_W-1:0] col_o;
  logic              valid_o, last_o, busy_o;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R10";
  bit done = 0;

  logic [ADDR_W-1:0] q[$];

  burst_col_seq #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .blen_i(blen_i), .order_i(order_i), .col_o(col_o),
    .valid_o(valid_o), .last_o(last_o), .busy_o(busy_o)
  );

  always #(PERIOD/2) clk = ~clk;

  // reference model: queue of remaining beat addresses
  always @(posedge clk) begin
    int n;
    int s;
    bit acc;
    if (rst) begin
      q.delete();
    end else begin
      acc = start_i && blen_i != 2'b00 && q.size() <= 1;
      if (q.size() > 0) void'(q.pop_front());
      if (acc) begin
        n = 1 << blen_i;
        s = int'(start_addr_i) % n;
        for (int k = 0; k < n; k++) begin
          int lowv;
          lowv = order_i ? (s ^ k) : ((s + k) % n);
          q.push_back((start_addr_i & ~ADDR_W'(n - 1)) | ADDR_W'(lowv));
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit ev, el, eb;
      ev = q.size() > 0;
      el = q.size() == 1;
      eb = q.size() > 1;
      n_cmp++;
      if (valid_o !== ev) begin
        n_bad++;
        $display("FAIL %s/R1/R6 valid_o: actual %b expected %b at %0t", phase, valid_o, ev, $time);
      end else if (ev && col_o !== q[0]) begin
        n_bad++;
        $display("FAIL %s/R3/R4/R5 col_o: actual %h expected %h at %0t", phase, col_o, q[0], $time);
      end else if (last_o !== el) begin
        n_bad++;
        $display("FAIL %s/R6 last_o: actual %b expected %b at %0t", phase, last_o, el, $time);
      end else if (busy_o !== eb) begin
        n_bad++;
        $display("FAIL %s/R7 busy_o: actual %b expected %b at %0t", phase, busy_o, eb, $time);
      end
    end
  end

  task automatic req(input logic [1:0] code, input logic ord, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    start_i = 1'b1; blen_i = code; order_i = ord; start_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R2";
    for (int c = 1; c < 4; c++)
      for (int o = 0; o < 2; o++)
        for (int s = 0; s < 8; s++) begin
          phase = o ? "R4" : "R3";
          req(2'(c), 1'(o), ADDR_W'(12'hA50 + s));
          idle(9);
        end
    phase = "R5";
    req(2'b01, 1'b0, 12'hFFF); idle(3);
    req(2'b10, 1'b1, 12'h803); idle(5);
    phase = "R1";
    req(2'b11, 1'b0, 12'h000); idle(9);
    phase = "R7";
    req(2'b11, 1'b1, 12'h125);
    req(2'b10, 1'b0, 12'h3C2);
    idle(9);
    phase = "R8";
    req(2'b10, 1'b0, 12'h1F2);
    while (!last_o) @(negedge clk);
    start_i = 1'b1; blen_i = 2'b11; order_i = 1'b1; start_addr_i = 12'h2AD;
    @(negedge clk);
    start_i = 1'b0;
    idle(10);
    phase = "R9";
    req(2'b00, 1'b0, 12'h111); idle(3);
    phase = "R10";
    req(2'b11, 1'b0, 12'h444); idle(2);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    idle(3);
    phase = "R7/R8 random";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      start_i = ($urandom_range(0, 2) == 0);
      blen_i = 2'($urandom_range(0, 3));
      order_i = 1'($urandom_range(0, 1));
      start_addr_i = ADDR_W'($urandom);
    end
    start_i = 1'b0;
    idle(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule